// File: doc/BRIEF.md
# Tearing-Effect Line Trigger

This block watches the tearing-effect sync output of a display panel and tells the frame transfer controller when to start pushing pixels. The panel signals the start of each frame (vsync) and the start of each scan line (hsync). The block counts lines from the most recent vsync. When the count reaches a programmed line number, it raises a one-clock start trigger. Starting the transfer at a chosen line keeps the write pointer behind the panel's read scan, so the picture does not tear.

The syncs can reach the block in two ways, selected by a mode input. In the two-pin mode, vsync and hsync arrive on separate pins. In the one-pin mode, both arrive on a single pin, and the block tells them apart by the measured pulse length. Each pulse is measured in base clock ticks after a two-flop synchroniser. A pulse is classified at its trailing edge against two programmed thresholds, and pulses below the applicable threshold are dropped as glitches. The active level of each sync is programmable.

Top module: `te_line_trigger`

## Requirements
- R1: While `rst_n` is low at a rising edge, `trig_out` is 0 and the line count returns to 0.
- R2: With `mode` equal to 0 (off) or 3 (reserved), no pulse on either pin ever raises `trig_out`.
- R3: In two-pin mode (`mode`=2), a pulse on `te_pin_a` lasting at least `vs_width` ticks is a vsync and clears the line count. A pulse on `te_pin_b` lasting at least `hs_width` ticks is an hsync and advances the count by one.
- R4: In one-pin mode (`mode`=1), a pulse on `te_pin_a` of `vs_width` ticks or more is a vsync. A pulse of at least `hs_width` but fewer than `vs_width` ticks is an hsync.
- R5: A pulse shorter than the threshold that would qualify it is ignored and leaves the line count unchanged.
- R6: A polarity input of 1 makes the sync active-high and 0 makes it active-low. `te_pin_b` follows `hs_active_high`. `te_pin_a` follows `vs_active_high` in both modes.
- R7: `trig_out` is high for exactly one cycle, on the vsync or hsync that makes the line count equal `trig_line`. With `trig_line`=0 it fires on the vsync itself.
- R8: For a qualifying pulse released before rising edge K+1, `trig_out` is high from rising edge K+3 until the next rising edge.
- R9: The line count stops at 2047 and does not wrap, so each frame yields at most one trigger.
- R10: In two-pin mode, when a vsync and an hsync complete in the same cycle, the vsync wins and the count ends at 0.
- R11: In one-pin mode, activity on `te_pin_b` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock; pulse widths are counted in its ticks |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | 0 off, 1 one-pin, 2 two-pin, 3 reserved (off) |
| hs_active_high | input | 1 | Active level of the hsync pin (1 = high) |
| vs_active_high | input | 1 | Active level of the vsync / combined pin (1 = high) |
| hs_width | input | 8 | Minimum hsync pulse length in ticks |
| vs_width | input | 8 | Minimum vsync pulse length in ticks |
| trig_line | input | 11 | Line count at which the trigger fires |
| te_pin_a | input | 1 | Vsync pin, or the combined sync pin in one-pin mode |
| te_pin_b | input | 1 | Hsync pin in two-pin mode |
| trig_out | output | 1 | One-cycle transfer start pulse |

## Verification
The trigger is due on the third rising edge after the falling clock edge where the deciding pulse is released. That delay is two synchroniser stages plus the registered trigger; the measurement and classification add no cycle. The bench drives every pin change at a falling edge and notes the rising-edge count at release. A monitor sampling at falling edges records the edge count and the pulse index whenever the trigger is high. One directed test compares that edge count with release plus three exactly. Pulses are spaced at least four cycles apart, so each trigger is credited to exactly one pulse before the next one is released.

// File: rtl/te_pkg.sv
// Shared definitions for the tearing-effect line trigger.
package te_pkg;
    typedef enum logic [1:0] {
        TE_OFF     = 2'd0,
        TE_ONE_PIN = 2'd1,
        TE_TWO_PIN = 2'd2,
        TE_RSVD    = 2'd3
    } te_mode_e;

    localparam int TE_LINE_W = 11;
endpackage

// File: rtl/te_sync2.sv
// Two-flop synchroniser for N asynchronous sync pins.
// Assumes the reset value given is each pin's inactive level, so no pulse
// is seen while the panel idles after reset.
module te_sync2 #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] idle_lvl,
    input  logic [N-1:0] pin_in,
    output logic [N-1:0] pin_sync
);
    logic [N-1:0] meta_q;
    logic [N-1:0] sync_q;

    // Two register stages per pin; reset loads the idle level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= idle_lvl;
            sync_q <= idle_lvl;
        end else begin
            meta_q <= pin_in;
            sync_q <= meta_q;
        end
    end

    assign pin_sync = sync_q;
endmodule

// File: rtl/te_pulse_meter.sv
// Measures the length of each active pulse in clock ticks.
// While the level is active, a run counter grows (saturating at all ones).
// In the first inactive cycle `done` is high and `width` holds the length.
// Assumes `act` is already synchronised and polarity-corrected.
module te_pulse_meter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         act,
    output logic         done,
    output logic [W-1:0] width
);
    localparam logic [W-1:0] RUN_MAX = '1;

    logic [W-1:0] run_q;

    // Count active ticks; clear when the level drops or the block is off.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            run_q <= '0;
        end else if (act) begin
            if (run_q != RUN_MAX) begin
                run_q <= run_q + 1'b1;
            end
        end else begin
            run_q <= '0;
        end
    end

    // Trailing edge: level gone, a run was recorded.
    assign done  = en && !act && (run_q != '0);
    assign width = run_q;

    // R4
    run_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && act && run_q != RUN_MAX) |=> (run_q == $past(run_q) + 1'b1));

    // R5
    run_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!act) |=> (run_q == '0));
endmodule

// File: rtl/te_classify.sv
// Turns finished pulses into vsync / hsync events according to the mode.
// One-pin: the length of the pin A pulse picks vsync (>= vs_w) or hsync
// (>= hs_w and < vs_w). Two-pin: pin A gives vsync, pin B gives hsync,
// each against its own threshold. Off and reserved modes give no events.
module te_classify #(
    parameter int W = 8
) (
    input  logic [1:0]   mode,
    input  logic         a_done,
    input  logic [W-1:0] a_width,
    input  logic         b_done,
    input  logic [W-1:0] b_width,
    input  logic [W-1:0] hs_w,
    input  logic [W-1:0] vs_w,
    output logic         vs_evt,
    output logic         hs_evt
);
    import te_pkg::*;

    te_mode_e mode_e;
    assign mode_e = te_mode_e'(mode);

    // Decode the finished pulses into events.
    always_comb begin
        vs_evt = 1'b0;
        hs_evt = 1'b0;
        unique case (mode_e)
            TE_ONE_PIN: begin
                vs_evt = a_done && (a_width >= vs_w);
                hs_evt = a_done && (a_width >= hs_w) && (a_width < vs_w);
            end
            TE_TWO_PIN: begin
                vs_evt = a_done && (a_width >= vs_w);
                hs_evt = b_done && (b_width >= hs_w);
            end
            default: begin
                vs_evt = 1'b0;
                hs_evt = 1'b0;
            end
        endcase
    end

    // R4
    always_comb begin
        if (mode_e == TE_ONE_PIN) begin
            one_pin_excl_chk: assert (!(vs_evt && hs_evt));
        end
    end
endmodule

// File: rtl/te_line_track.sv
// Line counter and trigger register.
// A vsync clears the count; an hsync advances it, holding at the maximum.
// The trigger is registered on the event that lands the count on the
// programmed line. Vsync has priority when both events arrive together.
module te_line_track #(
    parameter int LW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          vs_evt,
    input  logic          hs_evt,
    input  logic [LW-1:0] line,
    output logic          trig
);
    localparam logic [LW-1:0] LINE_MAX = '1;

    logic [LW-1:0] cnt_q;
    logic [LW-1:0] cnt_nx;
    logic          trig_q;

    assign cnt_nx = cnt_q + 1'b1;

    // Track the line number and register the trigger.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_q  <= '0;
            trig_q <= 1'b0;
        end else begin
            trig_q <= 1'b0;
            if (vs_evt) begin
                cnt_q  <= '0;
                trig_q <= (line == '0);
            end else if (hs_evt && cnt_q != LINE_MAX) begin
                cnt_q  <= cnt_nx;
                trig_q <= (cnt_nx == line);
            end
        end
    end

    assign trig = trig_q;

    // R3
    vsync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && vs_evt) |=> (cnt_q == '0));

    // R9
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cnt_q == LINE_MAX && !vs_evt) |=> (cnt_q == LINE_MAX));

    // R7
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_q |=> !trig_q);
endmodule

// File: rtl/te_line_trigger.sv
// Tearing-effect line trigger, top level.
// Synchronises the two sync pins, applies polarity, measures pulse lengths,
// classifies them into vsync / hsync and fires a one-cycle start trigger
// at the programmed line. Assumes configuration is static while enabled;
// a change is followed by a reset.
module te_line_trigger #(
    parameter int WIDTH_W = 8,
    parameter int LINE_W  = te_pkg::TE_LINE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         mode,
    input  logic               hs_active_high,
    input  logic               vs_active_high,
    input  logic [WIDTH_W-1:0] hs_width,
    input  logic [WIDTH_W-1:0] vs_width,
    input  logic [LINE_W-1:0]  trig_line,
    input  logic               te_pin_a,
    input  logic               te_pin_b,
    output logic               trig_out
);
    import te_pkg::*;

    localparam int NPIN = 2;

    logic              en;
    logic [NPIN-1:0]   pin_raw;
    logic [NPIN-1:0]   pin_idle;
    logic [NPIN-1:0]   pin_s;
    logic [NPIN-1:0]   pin_act;
    logic [NPIN-1:0]   p_done;
    logic [WIDTH_W-1:0] p_width [NPIN];
    logic              vs_evt;
    logic              hs_evt;

    // Enabled only in the two defined sync modes.
    assign en = (te_mode_e'(mode) == TE_ONE_PIN) || (te_mode_e'(mode) == TE_TWO_PIN);

    // Index 0 is pin A (vsync side), index 1 is pin B (hsync side).
    assign pin_raw  = {te_pin_b, te_pin_a};
    assign pin_idle = {~hs_active_high, ~vs_active_high};

    te_sync2 #(.N(NPIN)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .idle_lvl (pin_idle),
        .pin_in   (pin_raw),
        .pin_sync (pin_s)
    );

    // Active when the synchronised level differs from the idle level.
    assign pin_act = pin_s ^ pin_idle;

    for (genvar gi = 0; gi < NPIN; gi++) begin : g_meter
        te_pulse_meter #(.W(WIDTH_W)) u_meter (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (en),
            .act   (pin_act[gi]),
            .done  (p_done[gi]),
            .width (p_width[gi])
        );
    end

    te_classify #(.W(WIDTH_W)) u_class (
        .mode    (mode),
        .a_done  (p_done[0]),
        .a_width (p_width[0]),
        .b_done  (p_done[1]),
        .b_width (p_width[1]),
        .hs_w    (hs_width),
        .vs_w    (vs_width),
        .vs_evt  (vs_evt),
        .hs_evt  (hs_evt)
    );

    te_line_track #(.LW(LINE_W)) u_track (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en),
        .vs_evt (vs_evt),
        .hs_evt (hs_evt),
        .line   (trig_line),
        .trig   (trig_out)
    );

    // R2
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_out |-> $past(en));

    // R11
    pin_b_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (te_mode_e'(mode) == TE_ONE_PIN) |-> !(hs_evt && !p_done[0]));
endmodule

// File: tb/te_line_trigger_test.sv
`timescale 1ns/1ps
module te_line_trigger_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic        hpol = 1'b1;
    logic        vpol = 1'b1;
    logic [7:0]  hsw = 8'd2;
    logic [7:0]  vsw = 8'd4;
    logic [10:0] line = 11'd0;
    logic        pin_a = 1'b0;
    logic        pin_b = 1'b0;
    logic        trig;

    int checks = 0;
    int fails  = 0;
    int pc = 0;
    int evt_idx = -1;
    int rel_pc = 0;
    int trig_total = 0;
    int trig_evt = -1;
    int trig_pc = 0;

    always #2 clk = ~clk;

    te_line_trigger uut (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .hs_active_high(hpol), .vs_active_high(vpol),
        .hs_width(hsw), .vs_width(vsw), .trig_line(line),
        .te_pin_a(pin_a), .te_pin_b(pin_b), .trig_out(trig)
    );

    always_ff @(posedge clk) pc <= pc + 1;

    // Monitor: record every trigger seen at a falling edge.
    always @(negedge clk) begin
        if (trig) begin
            trig_total = trig_total + 1;
            trig_evt   = evt_idx;
            trig_pc    = pc;
        end
    end

    typedef struct packed {
        logic [1:0]  mode;
        logic        hpol;
        logic        vpol;
        logic [7:0]  hsw;
        logic [7:0]  vsw;
        logic [10:0] line;
        logic [7:0]  vpw;
        logic [7:0]  hpw;
        logic        hpin_b;
        logic [11:0] nh;
        logic [3:0]  exp_cnt;
        logic [11:0] exp_evt;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{2'd2,1'b1,1'b1,8'd2,8'd3,11'd3,8'd3,8'd2,1'b1,12'd5,4'd1,12'd3}, // R3
        '{2'd1,1'b1,1'b1,8'd3,8'd6,11'd2,8'd6,8'd3,1'b0,12'd4,4'd1,12'd2}, // R4
        '{2'd1,1'b1,1'b0,8'd2,8'd5,11'd1,8'd7,8'd4,1'b0,12'd3,4'd1,12'd1}, // R6
        '{2'd2,1'b1,1'b1,8'd2,8'd4,11'd0,8'd4,8'd2,1'b1,12'd3,4'd1,12'd0}, // R7
        '{2'd0,1'b1,1'b1,8'd2,8'd4,11'd1,8'd4,8'd2,1'b1,12'd3,4'd0,12'd0}, // R2
        '{2'd3,1'b1,1'b1,8'd2,8'd4,11'd1,8'd4,8'd2,1'b1,12'd3,4'd0,12'd0}, // R2
        '{2'd1,1'b1,1'b1,8'd3,8'd6,11'd1,8'd6,8'd2,1'b0,12'd4,4'd0,12'd0}, // R5
        '{2'd2,1'b1,1'b1,8'd4,8'd5,11'd1,8'd5,8'd3,1'b1,12'd4,4'd0,12'd0}, // R5
        '{2'd2,1'b1,1'b1,8'd2,8'd4,11'd0,8'd2,8'd2,1'b1,12'd2,4'd0,12'd0}, // R5
        '{2'd2,1'b0,1'b1,8'd2,8'd3,11'd2,8'd3,8'd2,1'b1,12'd3,4'd1,12'd2}, // R6
        '{2'd1,1'b1,1'b1,8'd2,8'd4,11'd1,8'd4,8'd2,1'b1,12'd3,4'd0,12'd0}, // R11
        '{2'd1,1'b1,1'b1,8'd3,8'd6,11'd1,8'd6,8'd6,1'b0,12'd3,4'd0,12'd0}  // R4
    };

    task automatic chk(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    task automatic do_reset();
        @(negedge clk);
        pin_a = ~vpol;
        pin_b = ~hpol;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 trig in reset", int'(trig), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    // Drive one pulse of w ticks on pin A or B (or both), then idle gap ticks.
    task automatic pulse(input bit on_a, input bit on_b, input int w,
                         input int gap, input int idx);
        @(negedge clk);
        if (on_a) pin_a = vpol;
        if (on_b) pin_b = hpol;
        repeat (w) @(negedge clk);
        pin_a   = ~vpol;
        pin_b   = ~hpol;
        evt_idx = idx;
        rel_pc  = pc;
        repeat (gap) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails = fails + 1;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        int base;
        // Vector table walk.
        for (int v = 0; v < NV; v++) begin
            mode = VECS[v].mode; hpol = VECS[v].hpol; vpol = VECS[v].vpol;
            hsw = VECS[v].hsw; vsw = VECS[v].vsw; line = VECS[v].line;
            do_reset();
            base = trig_total;
            trig_evt = -1;
            pulse(1'b1, 1'b0, int'(VECS[v].vpw), 6, 0);
            for (int h = 1; h <= int'(VECS[v].nh); h++) begin
                pulse(!VECS[v].hpin_b, VECS[v].hpin_b, int'(VECS[v].hpw), 6, h);
            end
            chk($sformatf("R3/R4/R5/R6/R7 vec%0d trigger count", v),
                trig_total - base, int'(VECS[v].exp_cnt));
            if (VECS[v].exp_cnt != 0)
                chk($sformatf("R7 vec%0d trigger line", v), trig_evt, int'(VECS[v].exp_evt));
        end

        // R8: exact latency from pulse release to trigger.
        mode = 2'd2; hpol = 1'b1; vpol = 1'b1; hsw = 8'd2; vsw = 8'd3; line = 11'd0;
        do_reset();
        base = trig_total;
        pulse(1'b1, 1'b0, 3, 8, 0);
        chk("R8 trigger count", trig_total - base, 1);
        chk("R8 latency edges", trig_pc - rel_pc, 3);

        // R10: simultaneous vsync and hsync, vsync wins.
        line = 11'd1;
        do_reset();
        base = trig_total;
        pulse(1'b1, 1'b1, 3, 6, 0);
        chk("R10 no trigger on tie", trig_total - base, 0);
        pulse(1'b0, 1'b1, 2, 6, 1);
        chk("R10 count restarted at 0", trig_total - base, 1);
        chk("R10 trigger on first hsync", trig_evt, 1);

        // R9: count holds at 2047, one trigger only.
        line = 11'd2047;
        do_reset();
        base = trig_total;
        pulse(1'b1, 1'b0, 3, 6, 0);
        for (int h = 1; h <= 2057; h++) pulse(1'b0, 1'b1, 2, 4, h);
        chk("R9 single trigger past max", trig_total - base, 1);
        chk("R9 trigger at line 2047", trig_evt, 2047);

        // R1: reset mid-frame and check quiet output.
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 trig low after reset", int'(trig), 0);
        rst_n = 1'b1;
        finish_run();
    end
endmodule